// File: doc/BRIEF.md
# Packed Byte Absolute-Difference Sum Unit

This block treats two XLEN-wide operands as vectors of unsigned bytes. It forms the absolute difference of every byte pair and adds all of these into one scalar that is XLEN bits wide. The block decodes two operation codes. The plain form returns that scalar. The accumulating form adds the old destination value to the scalar. The result wraps modulo 2^XLEN. The unit does not saturate and raises no flag.

The caller presents an operation for one cycle with `in_valid` high. It supplies the three fields of the instruction that identify the operation, the two sources and the old destination value. A valid operation that decodes as one of the two forms is accepted. Its result appears on `out_result` on the next cycle, with `out_valid` high. A small two-state controller tracks whether the output register holds a fresh result. In `ST_IDLE` no fresh result is present. In `ST_HOLD` a result was accepted on the previous edge. The controller has these transitions:
- `T_ISSUE`: IDLE to HOLD on an accepted operation.
- `T_CHAIN`: HOLD to HOLD on a further accepted operation.
- `T_DRAIN`: HOLD to IDLE when no operation is accepted.
- `T_WAIT`: IDLE to IDLE when no operation is accepted.

Top module: `byte_sad_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `out_result` is 0.
- R2: An operation is accepted only when `in_valid` is 1, `in_funct3` is 3'b000, `in_opcode` is 7'b1110111, and `in_funct7` is either 7'b1111110 (plain) or 7'b1111111 (accumulating). Any other input is ignored: `out_valid` stays 0 on the next cycle and `out_result` keeps its value.
- R3: Each byte lane `i` covers bits `[8i+7:8i]` of both sources. The lane is read as unsigned and contributes |a_i − b_i|.
- R4: The plain form returns the sum of all XLEN/8 lane differences, zero-extended. The largest value, XLEN/8 × 255, is returned exactly.
- R5: The accumulating form returns the old destination value plus the lane sum.
- R6: The accumulating sum wraps modulo 2^XLEN, and no other output changes.
- R7: `out_valid` is 1 exactly in the cycle after an accepted operation. The result of that operation is on `out_result` in the same cycle.
- R8: When no operation is accepted, `out_result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_funct7 | input | 7 | Upper function field of the instruction |
| in_funct3 | input | 3 | Middle function field of the instruction |
| in_opcode | input | 7 | Major opcode field of the instruction |
| in_src_a | input | XLEN | First packed-byte operand |
| in_src_b | input | XLEN | Second packed-byte operand |
| in_dest_old | input | XLEN | Old destination value for the accumulating form |
| out_valid | output | 1 | Fresh result present |
| out_result | output | XLEN | Registered result |

## Verification
One byte lane is swept over all 65,536 operand pairs while the other lanes stay fixed. A design that computed a signed difference, or the difference without the absolute value, would fail on the pairs where the byte order crosses 128 or where b > a. The checks all-zero against all-0xFF and 0xFF against 0x00 target overflow of the tree: a sum narrower than XLEN/8 × 255 would come back truncated. Equal operands must give exactly 0, or the old destination value in the accumulating form. An old destination value of all ones must wrap rather than saturate. Instructions with one field bit changed must leave `out_valid` low and the result register unchanged.

// File: rtl/byte_sad_pkg.sv
package byte_sad_pkg;
    localparam logic [6:0] OPC_PACKED   = 7'b1110111;
    localparam logic [2:0] F3_SAD       = 3'b000;
    localparam logic [6:0] F7_SAD_PLAIN = 7'b1111110;
    localparam logic [6:0] F7_SAD_ACC   = 7'b1111111;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PLAIN = 2'd1,
        SEL_ACC   = 2'd2
    } sad_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } sad_state_e;
endpackage

// File: rtl/byte_sad_decode.sv
module byte_sad_decode
    import byte_sad_pkg::*;
(
    input  logic       valid,
    input  logic [6:0] funct7,
    input  logic [2:0] funct3,
    input  logic [6:0] opcode,
    output sad_sel_e   sel
);
    logic fields_ok;

    always_comb begin
        fields_ok = valid && (funct3 == F3_SAD) && (opcode == OPC_PACKED);
        sel = SEL_NONE;
        if (fields_ok) begin
            unique case (funct7)
                F7_SAD_PLAIN: sel = SEL_PLAIN;
                F7_SAD_ACC:   sel = SEL_ACC;
                default:      sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/byte_sad_lane.sv
module byte_sad_lane (
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] absdiff
);
    always_comb begin
        if (a >= b) absdiff = a - b;
        else        absdiff = b - a;
    end
endmodule

// File: rtl/byte_sad_tree.sv
module byte_sad_tree #(
    parameter int LANES = 4,
    parameter int SUMW  = 10
) (
    input  logic [LANES*8-1:0] a,
    input  logic [LANES*8-1:0] b,
    output logic [SUMW-1:0]    sum
);
    logic [SUMW-1:0] node [1:2*LANES-1];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] d;
        byte_sad_lane u_lane (
            .a       (a[8*i +: 8]),
            .b       (b[8*i +: 8]),
            .absdiff (d)
        );
        assign node[LANES + i] = {{(SUMW-8){1'b0}}, d};
    end

    for (genvar n = 1; n < LANES; n++) begin : g_add
        assign node[n] = node[2*n] + node[2*n+1];
    end

    assign sum = node[1];
endmodule

// File: rtl/byte_sad_unit.sv
module byte_sad_unit
    import byte_sad_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [6:0]      in_funct7,
    input  logic [2:0]      in_funct3,
    input  logic [6:0]      in_opcode,
    input  logic [XLEN-1:0] in_src_a,
    input  logic [XLEN-1:0] in_src_b,
    input  logic [XLEN-1:0] in_dest_old,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    localparam int LANES   = XLEN / 8;
    localparam int SUM_MAX = LANES * 255;
    localparam int SUMW    = $clog2(SUM_MAX + 1);

    sad_sel_e        sel;
    sad_state_e      state_q, state_d;
    logic [SUMW-1:0] lane_sum;
    logic [XLEN-1:0] sum_ext, result_d, result_q;
    logic            accept;

    byte_sad_decode u_dec (
        .valid  (in_valid),
        .funct7 (in_funct7),
        .funct3 (in_funct3),
        .opcode (in_opcode),
        .sel    (sel)
    );

    byte_sad_tree #(.LANES(LANES), .SUMW(SUMW)) u_tree (
        .a   (in_src_a),
        .b   (in_src_b),
        .sum (lane_sum)
    );

    assign accept  = (sel != SEL_NONE);
    assign sum_ext = {{(XLEN-SUMW){1'b0}}, lane_sum};

    always_comb begin
        unique case (sel)
            SEL_ACC:   result_d = in_dest_old + sum_ext;
            SEL_PLAIN: result_d = sum_ext;
            default:   result_d = result_q;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = accept ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result_q <= '0;
        else if (accept) result_q <= result_d;
    end

    assign out_valid  = (state_q == ST_HOLD);
    assign out_result = result_q;

    // R7: an accepted operation yields out_valid on the next cycle
    assert_valid_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    // R2: an ignored input leaves out_valid low on the next cycle
    assert_ignored_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid);
    // R8: the result register holds when nothing is accepted
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(out_result));
    // R4: the lane sum never exceeds its bound
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lane_sum) <= SUM_MAX);
    // R4: the plain form result fits the bound
    assert_plain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PLAIN) |=> (out_result <= XLEN'(SUM_MAX)));
endmodule

// File: tb/byte_sad_unit_tb.sv
module byte_sad_unit_tb;
    localparam int XLEN = 32;
    localparam int LANES = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [6:0]      in_funct7 = '0;
    logic [2:0]      in_funct3 = '0;
    logic [6:0]      in_opcode = '0;
    logic [XLEN-1:0] in_src_a = '0, in_src_b = '0, in_dest_old = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_result;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    byte_sad_unit #(.XLEN(XLEN)) u_dut (
        .clk, .rst_n, .in_valid, .in_funct7, .in_funct3, .in_opcode,
        .in_src_a, .in_src_b, .in_dest_old, .out_valid, .out_result
    );

    function automatic logic [XLEN-1:0] ref_sad(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                                input logic [XLEN-1:0] d, input bit acc);
        logic [XLEN-1:0] s = '0;
        for (int i = 0; i < LANES; i++) begin
            int x = int'(a[8*i +: 8]);
            int y = int'(b[8*i +: 8]);
            s = s + XLEN'((x > y) ? x - y : y - x);
        end
        return acc ? s + d : s;
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, result visible after the next posedge, sample at the following negedge
    task automatic issue(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] op,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [XLEN-1:0] d);
        in_valid = 1'b1; in_funct7 = f7; in_funct3 = f3; in_opcode = op;
        in_src_a = a; in_src_b = b; in_dest_old = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic sad_op(input string tag, input bit acc, input logic [XLEN-1:0] a,
                          input logic [XLEN-1:0] b, input logic [XLEN-1:0] d);
        issue(acc ? 7'b1111111 : 7'b1111110, 3'b000, 7'b1110111, a, b, d);
        check({tag, " valid"}, XLEN'(out_valid), XLEN'(1));
        check(tag, out_result, ref_sad(a, b, d, acc));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset valid", XLEN'(out_valid), '0);
        check("R1 reset result", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        sad_op("R4 zeros vs ones", 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, '0);
        check("R4 max exact", out_result, 32'd1020);
        sad_op("R3 ones vs zeros", 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678);
        sad_op("R4 equal operands", 1'b0, 32'hA5C3_7E01, 32'hA5C3_7E01, 32'hFFFF_FFFF);
        check("R4 equal zero", out_result, '0);
        sad_op("R5 equal accumulate", 1'b1, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'hDEAD_BEEF);
        check("R5 acc value", out_result, 32'hDEAD_BEEF);
        sad_op("R6 wrap", 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R6 wrap value", out_result, 32'd1019);

        // R7: valid drops the cycle after an op with nothing new
        held = out_result;
        @(negedge clk);
        check("R7 valid drops", XLEN'(out_valid), '0);
        check("R8 result held", out_result, held);

        // R2: one-bit-off encodings are ignored
        issue(7'b1111100, 3'b000, 7'b1110111, 32'h0, 32'hFFFF_FFFF, '0);
        check("R2 bad funct7 valid", XLEN'(out_valid), '0);
        check("R2 bad funct7 result", out_result, held);
        issue(7'b1111110, 3'b001, 7'b1110111, 32'h0, 32'hFFFF_FFFF, '0);
        check("R2 bad funct3 valid", XLEN'(out_valid), '0);
        check("R2 bad funct3 result", out_result, held);
        issue(7'b1111111, 3'b000, 7'b1110011, 32'h0, 32'hFFFF_FFFF, '0);
        check("R2 bad opcode valid", XLEN'(out_valid), '0);
        check("R2 bad opcode result", out_result, held);
        in_funct7 = 7'b1111110; in_funct3 = 3'b000; in_opcode = 7'b1110111;
        in_src_a = 32'h0; in_src_b = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R2 no valid valid", XLEN'(out_valid), '0);
        check("R2 no valid result", out_result, held);

        // R3/R4/R5: sweep lane 0 exhaustively, other lanes fixed
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                bit acc = y[0];
                logic [XLEN-1:0] a = {24'h12F0_80, 8'(x)};
                logic [XLEN-1:0] b = {24'h7F01_81, 8'(y)};
                logic [XLEN-1:0] d = XLEN'(x * 65537 + y * 977);
                in_valid = 1'b1; in_funct7 = acc ? 7'b1111111 : 7'b1111110;
                in_funct3 = 3'b000; in_opcode = 7'b1110111;
                in_src_a = a; in_src_b = b; in_dest_old = d;
                @(posedge clk);
                @(negedge clk);
                check(acc ? "R5 sweep" : "R3 sweep", out_result, ref_sad(a, b, d, acc));
            end
        end
        check("R7 chained valid", XLEN'(out_valid), XLEN'(1));
        in_valid = 1'b0;

        // random patterns
        for (int k = 0; k < 200; k++) begin
            logic [XLEN-1:0] a = $urandom;
            logic [XLEN-1:0] b = $urandom;
            logic [XLEN-1:0] d = $urandom;
            sad_op("R4 random", k[0], a, b, d);
            @(negedge clk);
            check("R7 random drop", XLEN'(out_valid), '0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule